// File: doc/BRIEF.md
# Asynchronous SRAM access controller

This block lets a clocked system read and write an external asynchronous static RAM of 2^17 bytes. The user side is a request/ready handshake. A request carries a read/write flag, a 17-bit address and 8-bit write data. A read returns 8-bit data together with a one-cycle valid strobe.

The memory side drives the address bus, two chip selects (one active low, one active high), an active-low write strobe and an active-low output enable. The bidirectional data bus is split into an output value, an output-enable and an input value. The memory is selected only while both chip selects are active. A read needs the output enable low and the write strobe high. A write happens whenever the write strobe is low while the memory is selected.

Every wait is a whole number of clock cycles. Each count is a parameter, found by dividing a nanosecond minimum by the clock period and rounding up. With the default 10 ns clock:
- a read takes 2 cycles;
- a write takes 2 cycles;
- a write that directly follows a read takes one extra bus-turnaround cycle.

Top module: `sram_ctrl`

## Requirements
- R1: During reset, and in every cycle in which `ready_o` is high, the memory pins are idle. Idle means `mem_sel_no`=1, `mem_sel_o`=0, `mem_we_no`=1, `mem_oe_no`=1 and `mem_dq_oe_o`=0.
- R2: A request is taken at a rising clock edge only if `req_i` and `ready_o` are both high at that edge. A request raised while `ready_o` is low has no effect. `ready_o` is low from the cycle after acceptance until the operation completes.
- R3: A read (`we_i`=0) holds both selects active, `mem_oe_no` low and `mem_we_no` high. It captures `mem_dq_i` RD_CYC+1 cycles after acceptance, where RD_CYC is the larger of the access and output-enable delays divided by the clock period and rounded up. With defaults, `ready_o` returns high 2 cycles after acceptance.
- R4: Each read raises `rvalid_o` for exactly one cycle, with the captured byte on `rdata_o`. A write never raises `rvalid_o`.
- R5: A write (`we_i`=1) drives the data bus and holds `mem_we_no` low for WP_CYC cycles with `mem_oe_no` high. WP_CYC is the largest of the write-pulse, address-to-end and data-to-end minimums divided by the clock period and rounded up. One further cycle follows with `mem_we_no` high. With defaults, the write takes 2 cycles.
- R6: While `mem_we_no` is low, and in the cycle where it returns high, the address, the selects and the driven data do not change.
- R7: A write that directly follows a read first spends TURN_CYC cycles with the selects active, the write strobe high and the bus released. TURN_CYC is the output-release delay divided by the clock period and rounded up. With defaults, such a write takes 3 cycles.
- R8: The controller never drives the data bus while `mem_oe_no` is low. `mem_oe_no` and `mem_we_no` are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Operation request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 17 | Byte address |
| wdata_i | input | 8 | Write data |
| ready_o | output | 1 | Controller idle, request may be taken |
| rdata_o | output | 8 | Read data |
| rvalid_o | output | 1 | One-cycle strobe for `rdata_o` |
| mem_addr_o | output | 17 | Memory address bus |
| mem_sel_no | output | 1 | Chip select, active low |
| mem_sel_o | output | 1 | Chip select, active high |
| mem_we_no | output | 1 | Write strobe, active low |
| mem_oe_no | output | 1 | Output enable, active low |
| mem_dq_o | output | 8 | Data bus output value |
| mem_dq_oe_o | output | 1 | Data bus drive enable |
| mem_dq_i | input | 8 | Data bus input value |

## Verification
The two functions that can fall into the same few cycles are the release of the memory's read drive and the start of the next write's data drive. The bench provokes this by issuing a write at the first ready cycle after every read, across a sweep of walking-one and walking-zero addresses.

The memory model counts any cycle in which it and the controller drive the bus together. The bench also checks that the write-after-read length includes the turnaround cycle. The model returns a poison byte until an address has been presented for two full cycles, so an early capture shows up as a data miscompare.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_TURN,
    ST_WRITE,
    ST_REC
  } state_e;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctrl_timer.sv
module sram_ctrl_timer #(
  parameter int CNT_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             done_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

endmodule

// File: rtl/sram_ctrl_seq.sv
module sram_ctrl_seq
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W   = 17,
  parameter int DATA_W   = 8,
  parameter int CNT_W    = 2,
  parameter int RD_LD    = 1,
  parameter int WP_LD    = 0,
  parameter int TURN_LD  = 0,
  parameter bit HAS_TURN = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              tmr_done_i,
  output logic              tmr_load_o,
  output logic [CNT_W-1:0]  tmr_val_o,
  output logic              cap_o,
  output logic              ready_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_sel_no,
  output logic              mem_sel_o,
  output logic              mem_we_no,
  output logic              mem_oe_no,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe_o
);

  state_e state_q, state_d;
  logic   last_rd_q;
  logic   accept;
  logic   need_turn;

  assign ready_o   = (state_q == ST_IDLE);
  assign accept    = req_i && ready_o;
  assign need_turn = HAS_TURN && last_rd_q;

  always_comb begin
    state_d    = state_q;
    tmr_load_o = 1'b0;
    tmr_val_o  = '0;
    cap_o      = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          tmr_load_o = 1'b1;
          if (!we_i) begin
            state_d   = ST_READ;
            tmr_val_o = CNT_W'(RD_LD);
          end else if (need_turn) begin
            state_d   = ST_TURN;
            tmr_val_o = CNT_W'(TURN_LD);
          end else begin
            state_d   = ST_WRITE;
            tmr_val_o = CNT_W'(WP_LD);
          end
        end
      end
      ST_READ: begin
        if (tmr_done_i) begin
          state_d = ST_IDLE;
          cap_o   = 1'b1;
        end
      end
      ST_TURN: begin
        if (tmr_done_i) begin
          state_d    = ST_WRITE;
          tmr_load_o = 1'b1;
          tmr_val_o  = CNT_W'(WP_LD);
        end
      end
      ST_WRITE: if (tmr_done_i) state_d = ST_REC;
      ST_REC:   state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  // pin register stage: every memory control is a flop output
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      last_rd_q   <= 1'b0;
      mem_addr_o  <= '0;
      mem_sel_no  <= 1'b1;
      mem_sel_o   <= 1'b0;
      mem_we_no   <= 1'b1;
      mem_oe_no   <= 1'b1;
      mem_dq_o    <= '0;
      mem_dq_oe_o <= 1'b0;
    end else begin
      state_q <= state_d;
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            mem_addr_o <= addr_i;
            mem_dq_o   <= wdata_i;
            mem_sel_no <= 1'b0;
            mem_sel_o  <= 1'b1;
            if (!we_i) begin
              mem_oe_no <= 1'b0;
            end else if (!need_turn) begin
              mem_we_no   <= 1'b0;
              mem_dq_oe_o <= 1'b1;
            end
          end
        end
        ST_READ: begin
          if (tmr_done_i) begin
            mem_sel_no <= 1'b1;
            mem_sel_o  <= 1'b0;
            mem_oe_no  <= 1'b1;
            last_rd_q  <= 1'b1;
          end
        end
        ST_TURN: begin
          if (tmr_done_i) begin
            mem_we_no   <= 1'b0;
            mem_dq_oe_o <= 1'b1;
          end
        end
        ST_WRITE: if (tmr_done_i) mem_we_no <= 1'b1;
        ST_REC: begin
          mem_sel_no  <= 1'b1;
          mem_sel_o   <= 1'b0;
          mem_dq_oe_o <= 1'b0;
          last_rd_q   <= 1'b0;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/sram_ctrl_rdcap.sv
module sram_ctrl_rdcap #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= cap_i;
      if (cap_i) rdata_o <= dq_i;
    end
  end

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W        = 17,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_NS = 10,
  parameter int T_ACC_NS      = 10,
  parameter int T_OE_NS       = 5,
  parameter int T_WP_NS       = 9,
  parameter int T_AW_NS       = 9,
  parameter int T_DW_NS       = 5,
  parameter int T_HZ_NS       = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ready_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_sel_no,
  output logic              mem_sel_o,
  output logic              mem_we_no,
  output logic              mem_oe_no,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe_o,
  input  logic [DATA_W-1:0] mem_dq_i
);

  localparam int RD_CYC   = max2(1, ceil_div(max2(T_ACC_NS, T_OE_NS), CLK_PERIOD_NS));
  localparam int WP_CYC   = max2(1, max2(ceil_div(T_WP_NS, CLK_PERIOD_NS),
                                 max2(ceil_div(T_AW_NS, CLK_PERIOD_NS),
                                      ceil_div(T_DW_NS, CLK_PERIOD_NS))));
  localparam int TURN_CYC = ceil_div(T_HZ_NS, CLK_PERIOD_NS);
  localparam int MAX_CYC  = max2(RD_CYC, max2(WP_CYC, TURN_CYC));
  localparam int CNT_W    = max2(1, $clog2(MAX_CYC + 1));
  localparam bit HAS_TURN = (TURN_CYC > 0);
  localparam int TURN_LD  = HAS_TURN ? TURN_CYC - 1 : 0;

  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_done;
  logic             cap;

  sram_ctrl_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .done_o (tmr_done)
  );

  sram_ctrl_seq #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .CNT_W    (CNT_W),
    .RD_LD    (RD_CYC),
    .WP_LD    (WP_CYC - 1),
    .TURN_LD  (TURN_LD),
    .HAS_TURN (HAS_TURN)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .we_i        (we_i),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .tmr_done_i  (tmr_done),
    .tmr_load_o  (tmr_load),
    .tmr_val_o   (tmr_val),
    .cap_o       (cap),
    .ready_o     (ready_o),
    .mem_addr_o  (mem_addr_o),
    .mem_sel_no  (mem_sel_no),
    .mem_sel_o   (mem_sel_o),
    .mem_we_no   (mem_we_no),
    .mem_oe_no   (mem_oe_no),
    .mem_dq_o    (mem_dq_o),
    .mem_dq_oe_o (mem_dq_oe_o)
  );

  sram_ctrl_rdcap #(.DATA_W(DATA_W)) u_rdcap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cap_i    (cap),
    .dq_i     (mem_dq_i),
    .rdata_o  (rdata_o),
    .rvalid_o (rvalid_o)
  );

endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
  parameter int ADDR_W   = 17,
  parameter int DATA_W   = 8,
  parameter int TURN_CYC = 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              ready_o,
  input logic              rvalid_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_sel_no,
  input logic              mem_sel_o,
  input logic              mem_we_no,
  input logic              mem_oe_no,
  input logic [DATA_W-1:0] mem_dq_o,
  input logic              mem_dq_oe_o
);

  // consecutive sampled cycles with output enable released, saturating
  int oe_gap;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              oe_gap <= TURN_CYC + 1;
    else if (!mem_oe_no)      oe_gap <= 0;
    else if (oe_gap <= TURN_CYC) oe_gap <= oe_gap + 1;
  end

  // R1
  idle_pins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (mem_sel_no && !mem_sel_o && mem_we_no && mem_oe_no && !mem_dq_oe_o));

  // R2
  accept_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && ready_o) |=> !ready_o);

  // R3
  read_pins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_oe_no |-> (mem_we_no && !mem_sel_no && mem_sel_o));

  // R4
  rvalid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |=> !rvalid_o);

  // R5
  write_pins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_no |-> (mem_dq_oe_o && mem_oe_no && !mem_sel_no && mem_sel_o));

  // R6
  we_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_we_no && $past(!mem_we_no)) |-> ($stable(mem_addr_o) && $stable(mem_dq_o)));

  // R6
  we_end_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_no) |-> ($stable(mem_addr_o) && $stable(mem_dq_o) && mem_dq_oe_o
                          && !mem_sel_no && mem_sel_o));

  // R7
  turnaround_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_dq_oe_o) |-> (oe_gap > TURN_CYC));

  // R8
  no_contention_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_dq_oe_o |-> mem_oe_no);

endmodule

bind sram_ctrl sram_ctrl_chk #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .TURN_CYC (TURN_CYC)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .ready_o     (ready_o),
  .rvalid_o    (rvalid_o),
  .mem_addr_o  (mem_addr_o),
  .mem_sel_no  (mem_sel_no),
  .mem_sel_o   (mem_sel_o),
  .mem_we_no   (mem_we_no),
  .mem_oe_no   (mem_oe_no),
  .mem_dq_o    (mem_dq_o),
  .mem_dq_oe_o (mem_dq_oe_o)
);

// File: tb/sram_ctrl_test.sv
module sram_ctrl_test;

  localparam int CLK_NS  = 10;
  localparam int RD_BUSY = (10 + CLK_NS - 1) / CLK_NS + 1;  // R3
  localparam int WR_BUSY = (9 + CLK_NS - 1) / CLK_NS + 1;   // R5
  localparam int TURN    = (5 + CLK_NS - 1) / CLK_NS;       // R7
  localparam int NADDR   = 36;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [16:0] addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic        ready_o, rvalid_o;
  logic [7:0]  rdata_o;
  logic [16:0] mem_addr_o;
  logic        mem_sel_no, mem_sel_o, mem_we_no, mem_oe_no, mem_dq_oe_o;
  logic [7:0]  mem_dq_o;
  logic [7:0]  mem_dq_i = 8'hEE;

  always #5 clk = ~clk;

  sram_ctrl #(.CLK_PERIOD_NS(CLK_NS)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .ready_o(ready_o), .rdata_o(rdata_o), .rvalid_o(rvalid_o),
    .mem_addr_o(mem_addr_o), .mem_sel_no(mem_sel_no), .mem_sel_o(mem_sel_o),
    .mem_we_no(mem_we_no), .mem_oe_no(mem_oe_no), .mem_dq_o(mem_dq_o),
    .mem_dq_oe_o(mem_dq_oe_o), .mem_dq_i(mem_dq_i)
  );

  int checks = 0, fails = 0, cycles = 0;
  int n_reads = 0, n_pulses = 0, n_wr_issued = 0, n_we_falls = 0;
  int bad_hold = 0, contention = 0, rd_age = 0;
  logic [7:0]  mem [int];
  logic        pend = 1'b0, we_prev = 1'b1;
  logic [16:0] paddr;
  logic [7:0]  pdata;
  bit          prev_rd = 1'b0;

  function automatic logic [7:0] rdmem(input logic [16:0] a);
    return mem.exists(int'(a)) ? mem[int'(a)] : (a[7:0] ^ 8'h3C);
  endfunction

  function automatic logic [16:0] addr_of(input int i);
    if (i < 17)       return 17'(1) << i;
    else if (i < 34)  return ~(17'(1) << (i - 17));
    else if (i == 34) return 17'h00000;
    else              return 17'h1FFFF;
  endfunction

  function automatic logic [7:0] pat(input logic [16:0] a, input int k);
    return a[7:0] ^ a[15:8] ^ {7'd0, a[16]} ^ 8'(k * 53);
  endfunction

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  task automatic chk(input string r, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  // memory model and monitors, all on the falling edge
  always @(negedge clk) begin
    logic sel, mdrive;
    cycles++;
    if (rvalid_o) n_pulses++;
    if (!mem_we_no && we_prev) n_we_falls++;
    we_prev = mem_we_no;
    sel    = !mem_sel_no && mem_sel_o;
    mdrive = sel && !mem_oe_no && mem_we_no;
    if (mem_dq_oe_o && mdrive) contention++;
    if (!mem_oe_no && !mem_we_no) contention++;
    if (sel && !mem_we_no) begin
      if (pend && (mem_addr_o != paddr || mem_dq_o != pdata)) bad_hold++;
      pend  = 1'b1;
      paddr = mem_addr_o;
      pdata = mem_dq_oe_o ? mem_dq_o : 8'hEE;
    end else if (pend) begin
      mem[int'(paddr)] = pdata;
      pend = 1'b0;
    end
    if (mdrive) begin
      rd_age++;
      mem_dq_i = (rd_age >= 2) ? rdmem(mem_addr_o) : 8'hEE;
    end else begin
      rd_age   = 0;
      mem_dq_i = 8'hEE;
    end
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog R2: actual=%0d expected<150000 cycles", cycles);
      summary();
      $finish;
    end
  end

  task automatic op(input bit we, input logic [16:0] a, input logic [7:0] d);
    int busy, exp_busy;
    chk("R2 ready before request", int'(ready_o), 1);
    req_i = 1'b1; we_i = we; addr_i = a; wdata_i = d;
    @(negedge clk);
    req_i = 1'b0;
    busy  = 0;
    while (!ready_o && busy < 1000) begin
      @(negedge clk);
      busy++;
    end
    exp_busy = we ? (prev_rd ? WR_BUSY + TURN : WR_BUSY) : RD_BUSY;
    if (we) begin
      n_wr_issued++;
      chk(prev_rd ? "R7 write after read length" : "R5 write length", busy, exp_busy);
      chk("R4 no strobe on write", int'(rvalid_o), 0);
    end else begin
      n_reads++;
      chk("R3 read length", busy, exp_busy);
      chk("R4 strobe with data", int'(rvalid_o), 1);
      chk("R3 read data", int'(rdata_o), int'(d));
    end
    chk("R1 idle pins", int'({mem_sel_no, mem_sel_o, mem_we_no, mem_oe_no, mem_dq_oe_o}),
        int'(5'b10110));
    prev_rd = !we;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 pins in reset", int'({mem_sel_no, mem_sel_o, mem_we_no, mem_oe_no, mem_dq_oe_o}),
        int'(5'b10110));
    chk("R4 no strobe in reset", int'(rvalid_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", int'(ready_o), 1);

    for (int i = 0; i < NADDR; i++) op(1'b1, addr_of(i), pat(addr_of(i), 0));
    for (int i = 0; i < NADDR; i++) op(1'b0, addr_of(i), pat(addr_of(i), 0));
    // read then write at the first ready cycle: turnaround meets read release
    for (int i = 0; i < NADDR; i++) begin
      op(1'b0, addr_of(i), pat(addr_of(i), 0));
      op(1'b1, addr_of(i), pat(addr_of(i), 1));
    end

    // R2: a request pulsed while busy must not start a write
    begin
      int falls0, busy;
      falls0 = n_we_falls;
      req_i = 1'b1; we_i = 1'b1; addr_i = addr_of(0); wdata_i = 8'hA5;
      @(negedge clk);
      req_i = 1'b1; we_i = 1'b1; addr_i = addr_of(5); wdata_i = ~pat(addr_of(5), 1);
      @(negedge clk);
      req_i = 1'b0;
      busy = 1;
      while (!ready_o && busy < 1000) begin
        @(negedge clk);
        busy++;
      end
      n_wr_issued++;
      prev_rd = 1'b0;
      chk("R2 busy request ignored, length", busy, WR_BUSY);
      chk("R2 single write strobe", n_we_falls - falls0, 1);
    end
    op(1'b0, addr_of(5), pat(addr_of(5), 1));
    op(1'b0, addr_of(0), 8'hA5);

    for (int i = 1; i < NADDR; i++) op(1'b0, addr_of(i), pat(addr_of(i), 1));

    repeat (3) @(negedge clk);
    chk("R4 one strobe per read", n_pulses, n_reads);
    chk("R2 write strobes per accepted write", n_we_falls, n_wr_issued);
    chk("R6 address and data held through write", bad_hold, 0);
    chk("R8 no bus contention", contention, 0);
    summary();
    $finish;
  end

endmodule